// File: doc/BRIEF.md
# Multi-Lane Block Encoder Spreader and Merger

This block sits between a full-rate serial message source and a set of N external block encoders. Each encoder lane runs at 1/N of the aggregate rate. On the way in, the block hands each incoming message symbol to exactly one lane. On the way out, it collects the lanes' codeword symbols and emits them as one full-rate stream for a modulator mapper. The encoders are reached through per-lane valid/ready pairs.

Two mode inputs pick the ordering on each side independently. The block can send whole blocks: k message symbols per lane on input, or n codeword symbols per lane on output. It can also stagger symbol by symbol, so that symbol j goes to or comes from lane j mod N. A cover-code option bitwise inverts the input symbols of one chosen lane, so that a receiver can tell the lanes apart. An offset-QPSK option marks each merged symbol as belonging to the I rail or the Q rail.

A start pulse or a synchronous reset returns every counter to lane 0. Mode settings are taken up only when the block is idle. The block is idle when both counters sit at the start of a round, no round is in flight, and no symbol moves in that cycle.

Top module: `laneSpreadMerge`

## Requirements
- R1: With inStagger=0, within each round of N*k input symbols, input symbol q goes to lane q/k (integer division). Lane L therefore receives k consecutive symbols before lane L+1 receives any.
- R2: With inStagger=1, within each round, input symbol q goes to lane q mod N.
- R3: With outStagger=0, within each round of N*n output symbols, output position p is codeword symbol p mod n of lane p/n. Lane L's whole codeword leaves before any symbol of lane L+1.
- R4: With outStagger=1, within each round, output position p is codeword symbol p/N of lane p mod N.
- R5: With coverEn=1, every symbol routed to lane coverLaneSel is presented as the bitwise inverse of inData. Symbols routed to all other lanes pass unchanged.
- R6: With oqpskEn=1, the merged symbols at 0-based positions 0, 2, 4 (the first, third, fifth and so on since the start pulse) raise oqIValid, and the symbols at odd positions raise oqQValid. Both strobes go high together with outValid. With oqpskEn=0, both strobes stay low.
- R7: The output is registered. outValid and outData appear in the cycle after a lane handshake (laneOutValid and laneOutReady both high on the selected lane). When the selected lane is not valid, nothing is emitted and the order is kept, with no symbol lost or repeated.
- R8: After reset, and in the cycle after a start pulse, outValid is low. Both counters restart at lane 0, and the I/Q position restarts at 0. No handshake takes place during the start pulse.
- R9: A change on inStagger, outStagger, coverEn, coverLaneSel or oqpskEn during a round has no effect until the block is idle. At that point the new setting applies without a further start pulse.
- R10: At most one bit of laneInValid is high, and it is the bit of the lane selected by R1/R2. inReady equals that lane's laneInReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startPulse | input | 1 | Restart counters at lane 0 and load the mode inputs |
| inStagger | input | 1 | Input split: 0 whole blocks, 1 symbol staggering |
| outStagger | input | 1 | Output merge: 0 whole codewords, 1 symbol staggering |
| coverEn | input | 1 | Enable lane input inversion |
| coverLaneSel | input | LW | Lane whose input is inverted |
| oqpskEn | input | 1 | Enable I/Q rail marking |
| inValid | input | 1 | Message symbol valid |
| inData | input | SYM_W | Message symbol |
| inReady | output | 1 | Message symbol accepted when high with inValid |
| laneInValid | output | NUM_LANES | Per-lane message valid |
| laneInData | output | NUM_LANES*SYM_W | Per-lane message symbol, lane L at bits L*SYM_W upward |
| laneInReady | input | NUM_LANES | Per-lane message ready |
| laneOutValid | input | NUM_LANES | Per-lane codeword symbol valid |
| laneOutData | input | NUM_LANES*SYM_W | Per-lane codeword symbol, lane L at bits L*SYM_W upward |
| laneOutReady | output | NUM_LANES | Per-lane codeword symbol taken |
| outValid | output | 1 | Merged symbol valid |
| outData | output | SYM_W | Merged symbol |
| oqIValid | output | 1 | Merged symbol belongs to the I rail |
| oqQValid | output | 1 | Merged symbol belongs to the Q rail |

## Verification
The sweep covers all four split/merge ordering pairs, each with the cover code off and with the cover code on every lane. Each message pattern uses a different stride, so a mis-routed, inverted or reordered symbol changes the observed codeword and its parity. Runs alternate I/Q marking, and every third cycle of selected runs holds the lanes' outputs invalid, which shows up any loss or duplication under stall. A final pair of runs flips the input split in the middle of a round. The first run shows that the flip is ignored until the block is idle, and the second, without a start pulse, shows that the flip is then in force.

// File: rtl/laneSpreadMergePkg.sv
package laneSpreadMergePkg;
  typedef struct packed {
    logic inEn;
    logic outEn;
    logic coverOn;
    logic oqOn;
    logic phaseQ;
  } lsmStrobe_t;
endpackage

// File: rtl/laneSpreadMergeCtrl.sv
module laneSpreadMergeCtrl
  import laneSpreadMergePkg::*;
#(
  parameter int N = 4,
  parameter int K = 4,
  parameter int CWN = 6,
  parameter int LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          startPulse,
  input  logic          inStagReq,
  input  logic          outStagReq,
  input  logic          coverReq,
  input  logic [LW-1:0] coverLaneReq,
  input  logic          oqReq,
  input  logic          inValid,
  input  logic          selInReady,
  input  logic          selOutValid,
  output lsmStrobe_t    st,
  output logic [LW-1:0] inLane,
  output logic [LW-1:0] outLane,
  output logic [LW-1:0] coverLane
);
  localparam int IW = $clog2(N * K + 1);
  localparam int OW = $clog2(N * CWN + 1);
  localparam int PW = 3;

  logic [IW-1:0] inIdx, inSub;
  logic [OW-1:0] outIdx, outSub;
  logic [PW-1:0] pending;
  logic inStag, outStag, coverOn, oqOn, phaseQ;
  logic inFire, outFire, inLast, outLast, idle;

  always_comb begin
    inFire  = !startPulse && inValid && selInReady;
    outFire = !startPulse && selOutValid;
    inLast  = (inIdx == IW'(N * K - 1));
    outLast = (outIdx == OW'(N * CWN - 1));
    idle    = (pending == '0) && (inIdx == '0) && (outIdx == '0) && !inFire && !outFire;
    st.inEn    = !startPulse;
    st.outEn   = !startPulse;
    st.coverOn = coverOn;
    st.oqOn    = oqOn;
    st.phaseQ  = phaseQ;
  end

  always_ff @(posedge clk) begin
    if (rst || startPulse) begin
      inIdx <= '0; inSub <= '0; inLane <= '0;
      outIdx <= '0; outSub <= '0; outLane <= '0;
      pending <= '0;
      phaseQ <= 1'b0;
      if (rst) begin
        inStag <= 1'b0; outStag <= 1'b0; coverOn <= 1'b0; coverLane <= '0; oqOn <= 1'b0;
      end else begin
        inStag <= inStagReq; outStag <= outStagReq; coverOn <= coverReq;
        coverLane <= coverLaneReq; oqOn <= oqReq;
      end
    end else begin
      if (inFire) begin
        if (inLast) begin
          inIdx <= '0; inSub <= '0; inLane <= '0;
        end else begin
          inIdx <= inIdx + 1'b1;
          if (inStag) begin
            inLane <= (inLane == LW'(N - 1)) ? '0 : inLane + 1'b1;
          end else if (inSub == IW'(K - 1)) begin
            inSub <= '0;
            inLane <= inLane + 1'b1;
          end else begin
            inSub <= inSub + 1'b1;
          end
        end
      end
      if (outFire) begin
        phaseQ <= ~phaseQ;
        if (outLast) begin
          outIdx <= '0; outSub <= '0; outLane <= '0;
        end else begin
          outIdx <= outIdx + 1'b1;
          if (outStag) begin
            outLane <= (outLane == LW'(N - 1)) ? '0 : outLane + 1'b1;
          end else if (outSub == OW'(CWN - 1)) begin
            outSub <= '0;
            outLane <= outLane + 1'b1;
          end else begin
            outSub <= outSub + 1'b1;
          end
        end
      end
      case ({inFire && inLast, outFire && outLast})
        2'b10:   pending <= pending + 1'b1;
        2'b01:   pending <= pending - 1'b1;
        default: pending <= pending;
      endcase
      if (idle) begin
        inStag <= inStagReq; outStag <= outStagReq; coverOn <= coverReq;
        coverLane <= coverLaneReq; oqOn <= oqReq;
      end
    end
  end
endmodule

// File: rtl/laneSpreadMergeDp.sv
module laneSpreadMergeDp
  import laneSpreadMergePkg::*;
#(
  parameter int N = 4,
  parameter int W = 4,
  parameter int LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  lsmStrobe_t     st,
  input  logic [LW-1:0]  inLane,
  input  logic [LW-1:0]  outLane,
  input  logic [LW-1:0]  coverLane,
  input  logic           inValid,
  input  logic [W-1:0]   inData,
  output logic           inReady,
  output logic [N-1:0]   laneInValid,
  output logic [N*W-1:0] laneInData,
  input  logic [N-1:0]   laneInReady,
  input  logic [N-1:0]   laneOutValid,
  input  logic [N*W-1:0] laneOutData,
  output logic [N-1:0]   laneOutReady,
  output logic           selInReady,
  output logic           selOutValid,
  output logic           outValid,
  output logic [W-1:0]   outData,
  output logic           oqIValid,
  output logic           oqQValid
);
  logic [W-1:0] selOutData;
  logic outFire;

  for (genvar g = 0; g < N; g++) begin : gLane
    assign laneInValid[g]      = st.inEn && inValid && (inLane == LW'(g));
    assign laneInData[g*W +: W] = (st.coverOn && coverLane == LW'(g)) ? ~inData : inData;
    assign laneOutReady[g]     = st.outEn && (outLane == LW'(g));
  end

  always_comb begin
    selInReady  = laneInReady[inLane];
    selOutValid = laneOutValid[outLane];
    selOutData  = laneOutData[outLane*W +: W];
    inReady     = st.inEn && selInReady;
    outFire     = st.outEn && selOutValid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outData  <= '0;
      oqIValid <= 1'b0;
      oqQValid <= 1'b0;
    end else begin
      outValid <= outFire;
      if (outFire) outData <= selOutData;
      oqIValid <= outFire && st.oqOn && !st.phaseQ;
      oqQValid <= outFire && st.oqOn && st.phaseQ;
    end
  end
endmodule

// File: rtl/laneSpreadMerge.sv
module laneSpreadMerge
  import laneSpreadMergePkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int MSG_LEN = 4,
  parameter int CW_LEN = 6,
  parameter int SYM_W = 4,
  localparam int LW = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   startPulse,
  input  logic                   inStagger,
  input  logic                   outStagger,
  input  logic                   coverEn,
  input  logic [LW-1:0]          coverLaneSel,
  input  logic                   oqpskEn,
  input  logic                   inValid,
  input  logic [SYM_W-1:0]       inData,
  output logic                   inReady,
  output logic [NUM_LANES-1:0]   laneInValid,
  output logic [NUM_LANES*SYM_W-1:0] laneInData,
  input  logic [NUM_LANES-1:0]   laneInReady,
  input  logic [NUM_LANES-1:0]   laneOutValid,
  input  logic [NUM_LANES*SYM_W-1:0] laneOutData,
  output logic [NUM_LANES-1:0]   laneOutReady,
  output logic                   outValid,
  output logic [SYM_W-1:0]       outData,
  output logic                   oqIValid,
  output logic                   oqQValid
);
  lsmStrobe_t st;
  logic [LW-1:0] inLane, outLane, coverLane;
  logic selInReady, selOutValid;

  laneSpreadMergeCtrl #(.N(NUM_LANES), .K(MSG_LEN), .CWN(CW_LEN), .LW(LW)) u_ctrl (
    .clk(clk), .rst(rst), .startPulse(startPulse),
    .inStagReq(inStagger), .outStagReq(outStagger), .coverReq(coverEn),
    .coverLaneReq(coverLaneSel), .oqReq(oqpskEn),
    .inValid(inValid), .selInReady(selInReady), .selOutValid(selOutValid),
    .st(st), .inLane(inLane), .outLane(outLane), .coverLane(coverLane)
  );

  laneSpreadMergeDp #(.N(NUM_LANES), .W(SYM_W), .LW(LW)) u_dp (
    .clk(clk), .rst(rst), .st(st),
    .inLane(inLane), .outLane(outLane), .coverLane(coverLane),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .laneInValid(laneInValid), .laneInData(laneInData), .laneInReady(laneInReady),
    .laneOutValid(laneOutValid), .laneOutData(laneOutData), .laneOutReady(laneOutReady),
    .selInReady(selInReady), .selOutValid(selOutValid),
    .outValid(outValid), .outData(outData), .oqIValid(oqIValid), .oqQValid(oqQValid)
  );
endmodule

// File: rtl/laneSpreadMergeChk.sv
module laneSpreadMergeChk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         startPulse,
  input logic         inValid,
  input logic         inReady,
  input logic [N-1:0] laneInValid,
  input logic [N-1:0] laneOutValid,
  input logic [N-1:0] laneOutReady,
  input logic         outValid,
  input logic         oqIValid,
  input logic         oqQValid
);
  p_in_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(laneInValid));

  p_accept_one_lane_r10: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |-> ($countones(laneInValid) == 1));

  p_stall_no_out_r7: assert property (@(posedge clk) disable iff (rst)
    !(|(laneOutValid & laneOutReady)) |=> !outValid);

  p_iq_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(oqIValid && oqQValid));

  p_iq_with_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (oqIValid || oqQValid) |-> outValid);

  p_start_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    startPulse |=> !outValid);
endmodule

bind laneSpreadMerge laneSpreadMergeChk #(.N(NUM_LANES)) u_chk (
  .clk(clk), .rst(rst), .startPulse(startPulse), .inValid(inValid), .inReady(inReady),
  .laneInValid(laneInValid), .laneOutValid(laneOutValid), .laneOutReady(laneOutReady),
  .outValid(outValid), .oqIValid(oqIValid), .oqQValid(oqQValid)
);

// File: tb/laneSpreadMerge_tb.sv
module encStub #(
  parameter int K = 4,
  parameter int CWN = 6,
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         inValid,
  input  logic [W-1:0] inData,
  output logic         inReady,
  input  logic         outReady,
  output logic         outValid,
  output logic [W-1:0] outData
);
  logic [W-1:0] msg [K];
  logic [7:0] cnt, pos;
  logic full;
  logic [W-1:0] sum;

  always_comb begin
    sum = '0;
    for (int i = 0; i < K; i++) sum = sum + msg[i];
    inReady  = !full;
    outValid = full && !hold;
    outData  = (pos < 8'(K)) ? msg[pos[$clog2(K)-1:0]] : W'(sum + W'(pos - 8'(K) + 8'd1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; pos <= '0; full <= 1'b0;
      for (int i = 0; i < K; i++) msg[i] <= '0;
    end else if (!full && inValid) begin
      msg[cnt[$clog2(K)-1:0]] <= inData;
      if (cnt == 8'(K - 1)) begin cnt <= '0; full <= 1'b1; end
      else cnt <= cnt + 8'd1;
    end else if (outValid && outReady) begin
      if (pos == 8'(CWN - 1)) begin pos <= '0; full <= 1'b0; end
      else pos <= pos + 8'd1;
    end
  end
endmodule

module laneSpreadMerge_tb;
  localparam int N = 4;
  localparam int K = 4;
  localparam int CWN = 6;
  localparam int W = 4;
  localparam int LW = 2;
  localparam int MAXR = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, startPulse, inStagger, outStagger, coverEn, oqpskEn, inValid, inReady;
  logic [LW-1:0] coverLaneSel;
  logic [W-1:0] inData;
  logic [N-1:0] laneInValid, laneInReady, laneOutValid, laneOutReady;
  logic [N*W-1:0] laneInData, laneOutData;
  logic outValid, oqIValid, oqQValid;
  logic [W-1:0] outData;

  logic holdEn;
  int cyc;
  logic hold;
  always @(posedge clk) cyc <= cyc + 1;
  assign hold = holdEn && (cyc % 3 == 1);

  laneSpreadMerge #(.NUM_LANES(N), .MSG_LEN(K), .CW_LEN(CWN), .SYM_W(W)) u_dut (
    .clk(clk), .rst(rst), .startPulse(startPulse), .inStagger(inStagger),
    .outStagger(outStagger), .coverEn(coverEn), .coverLaneSel(coverLaneSel),
    .oqpskEn(oqpskEn), .inValid(inValid), .inData(inData), .inReady(inReady),
    .laneInValid(laneInValid), .laneInData(laneInData), .laneInReady(laneInReady),
    .laneOutValid(laneOutValid), .laneOutData(laneOutData), .laneOutReady(laneOutReady),
    .outValid(outValid), .outData(outData), .oqIValid(oqIValid), .oqQValid(oqQValid)
  );

  for (genvar g = 0; g < N; g++) begin : gEnc
    encStub #(.K(K), .CWN(CWN), .W(W)) u_enc (
      .clk(clk), .rst(rst), .hold(hold),
      .inValid(laneInValid[g]), .inData(laneInData[g*W +: W]), .inReady(laneInReady[g]),
      .outReady(laneOutReady[g]), .outValid(laneOutValid[g]), .outData(laneOutData[g*W +: W])
    );
  end

  int nChk = 0, nFail = 0;
  bit summaryDone = 0;
  int msgs [N*K*MAXR];
  bit expInStag, expOutStag, expCov, expOq;
  int expCl;
  int outCnt, outTot;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int inputVal(int r, int L, int m);
    int gi, v;
    gi = expInStag ? (r*N*K + L + N*m) : (r*N*K + L*K + m);
    v = msgs[gi];
    if (expCov && L == expCl) v = (~v) & 15;
    return v;
  endfunction

  function automatic int expOutSym(int idx);
    int r, p, L, c, s;
    r = idx / (N*CWN);
    p = idx % (N*CWN);
    if (expOutStag) begin L = p % N; c = p / N; end
    else begin L = p / CWN; c = p % CWN; end
    if (c < K) return inputVal(r, L, c);
    s = 0;
    for (int m = 0; m < K; m++) s += inputVal(r, L, m);
    return (s + c - K + 1) & 15;
  endfunction

  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (outCnt >= outTot) begin
        check(1'b0, "R7 extra output", outCnt, outTot);
      end else begin
        check(outData == W'(expOutSym(outCnt)),
              expOutStag ? "R4 staggered output order" : "R3 block output order",
              int'(outData), expOutSym(outCnt));
        check(oqIValid == (expOq && (outCnt % 2 == 0)), "R6 I rail flag",
              int'(oqIValid), int'(expOq && (outCnt % 2 == 0)));
        check(oqQValid == (expOq && (outCnt % 2 == 1)), "R6 Q rail flag",
              int'(oqQValid), int'(expOq && (outCnt % 2 == 1)));
      end
      outCnt++;
    end
  end

  task automatic runCase(input bit inS, input bit outS, input bit cov, input int cl,
                         input bit oq, input bit stall, input int rounds,
                         input int flipAt, input bit doStart, input int seed);
    int q, lane, tmo;
    @(negedge clk);
    for (int i = 0; i < N*K*MAXR; i++) msgs[i] = (i*(2*seed+1) + seed) & 15;
    holdEn = stall;
    if (doStart) begin
      inStagger = inS; outStagger = outS; coverEn = cov; coverLaneSel = LW'(cl); oqpskEn = oq;
      startPulse = 1'b1;
      @(negedge clk);
      startPulse = 1'b0;
      check(outValid == 1'b0, "R8 quiet after start", int'(outValid), 0);
    end
    expInStag = inS; expOutStag = outS; expCov = cov; expCl = cl; expOq = oq;
    outCnt = 0;
    outTot = rounds * N * CWN;
    for (q = 0; q < rounds*N*K; q++) begin
      inValid = 1'b1;
      inData = W'(msgs[q]);
      tmo = 0;
      forever begin
        #1;
        if (inReady || tmo > 2000) break;
        @(negedge clk);
        tmo++;
      end
      lane = inS ? ((q % (N*K)) % N) : ((q % (N*K)) / K);
      check(laneInValid == N'(1 << lane), inS ? "R2 staggered input lane" : "R1 block input lane",
            int'(laneInValid), 1 << lane);
      check(laneInData[lane*W +: W] == W'(inputVal(q / (N*K), lane, inS ? ((q%(N*K))/N) : ((q%(N*K))%K))),
            "R5 lane input value", int'(laneInData[lane*W +: W]),
            inputVal(q / (N*K), lane, inS ? ((q%(N*K))/N) : ((q%(N*K))%K)));
      @(negedge clk);
      if (q == flipAt) inStagger = ~inStagger;
    end
    inValid = 1'b0;
    tmo = 0;
    while (outCnt < outTot && tmo < 4000) begin @(negedge clk); tmo++; end
    check(outCnt == outTot, "R7 output count", outCnt, outTot);
    repeat (8) @(negedge clk);
    check(outCnt == outTot, "R7 no extra output", outCnt, outTot);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    if (!summaryDone) begin
      summaryDone = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    end
    $finish;
  end

  initial begin
    int n;
    rst = 1'b1; startPulse = 1'b0; inStagger = 1'b0; outStagger = 1'b0; coverEn = 1'b0;
    coverLaneSel = '0; oqpskEn = 1'b0; inValid = 1'b0; inData = '0; holdEn = 1'b0;
    outCnt = 0; outTot = 0; cyc = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R8 reset outValid", int'(outValid), 0);
    check(inReady == 1'b1, "R10 reset inReady from lane 0", int'(inReady), 1);
    check(laneInValid == '0, "R10 no lane valid when idle", int'(laneInValid), 0);
    n = 0;
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++)
        for (int cv = 0; cv < 5; cv++) begin
          runCase(a[0], b[0], cv < 4, cv % 4, n[0], (n % 3) == 0, 2, -1, 1'b1, n + 1);
          n++;
        end
    // R9: flip during a round is ignored; after idle it applies without a start pulse
    runCase(1'b0, 1'b1, 1'b1, 2, 1'b1, 1'b1, 1, 5, 1'b1, 7);
    runCase(1'b1, 1'b1, 1'b1, 2, 1'b1, 1'b0, 1, -1, 1'b0, 9);
    if (!summaryDone) begin
      summaryDone = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    end
    $finish;
  end
endmodule